// File: doc/BRIEF.md
# Management Register Bridge

This block sits between a byte-wide host register port and the two-wire station management bus of an Ethernet PHY. It formats clause-22 read and write frames, drives the management clock and data pins, and gathers the reply of a read. The host never sees the serial bus. It loads a PHY register number and data bytes into small registers, then polls a busy flag.

A write starts when the host stores the upper data byte. A read starts when the host sets a command bit, and that bit stays set after the read until the host clears it. A scan bit keeps repeating reads of the selected register until it is cleared. A frame is 32 preamble ones followed by 32 frame bits. Each bit takes `CLK_DIV` system clocks, so a 25 MHz clock with the default divider of 4 gives 10.24 µs per frame.

Register offsets on `reg_addr_i`:

- 0: register select, bits 4:0.
- 1: command. Bit 0 is the read request and bit 1 is scan.
- 2: status. Bit 0 is busy. Writes to this offset do nothing.
- 3: write data, low byte.
- 4: write data, high byte.
- 5: read data, low byte.
- 6: read data, high byte.
- 7: reads zero.

Top module: `mgmt_bridge`

## Requirements
- R1: After reset every offset reads zero, `mdc_o` is low and `mdio_oe_o` is low. While no frame is running, both stay low.
- R2: A write to offset 4 while idle stores the byte and starts a write frame. Status bit 0 reads 1 from the cycle after that write.
- R3: Busy lasts exactly 64*`CLK_DIV` cycles and then clears with no host action.
- R4: The frame on `mdio_o` is sent MSB first, one bit per MDC period. It is 32 ones, then start `01`, then opcode (`10` for read, `01` for write), then `PHY_ADDR` (5 bits), then the selected register (5 bits). The turnaround follows (`10` on write), then 16 data bits. For a write the data field is {high byte, low byte}, and the low byte comes from the last write to offset 3.
- R5: A write to offset 1 with bit 0 set starts a read frame, provided the block is idle and the read bit was clear. `mdio_oe_o` is low from bit 46 (the turnaround) to the end of that frame.
- R6: Each bit period keeps MDC low for its first `CLK_DIV`/2 cycles and high for the rest. `mdio_o` and `mdio_oe_o` change only when MDC falls, and `mdio_i` is sampled on the cycle MDC rises.
- R7: The 16 bits sampled in a read show up at offsets 5 (bits 7:0) and 6 (bits 15:8) in the same cycle that busy clears. Reading them in either order gives the same value.
- R8: The read bit stays 1 after the read finishes. Writing 1 to it again starts nothing. Clearing it and then setting it starts a new read.
- R9: While busy, a write to offset 4 is ignored, and so is setting the read or scan bit. The stored value does not change and no new frame follows. Clearing a command bit is always accepted.
- R10: While the scan bit is set, read frames of the selected register repeat with one idle cycle between them, and each one updates offsets 5 and 6. Once scan is cleared, the frame in progress finishes and no new one starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Host write byte |
| reg_rdata_o | output | 8 | Byte at `reg_addr_i` |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench aims at the edges of a frame. It writes the high byte in the first idle cycle after busy falls; a design that held busy for one cycle too many would drop that write. It writes the high byte and sets the read bit in the middle of a frame; a design that let those through would restart the serial stream or overwrite the stored data. It re-sets an already set read bit and clears scan in the middle of a frame, which exposes designs that start reads on a level instead of a 0-to-1 change, or that cut a scan frame short. A bit-exact capture of a write frame, together with the released-enable window of a read, catches a wrong opcode, a wrong turnaround or data shifted by one bit.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned FRM_LEN  = 32;
  localparam int unsigned TOT_BITS = PRE_LEN + FRM_LEN;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned RA_W     = 5;
  localparam int unsigned AW       = 3;
  localparam int unsigned TA_BIT   = PRE_LEN + 14;
  localparam int unsigned DAT_BIT  = PRE_LEN + 16;

  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;

  localparam logic [AW-1:0] A_SEL  = 3'd0;
  localparam logic [AW-1:0] A_CMD  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_WLO  = 3'd3;
  localparam logic [AW-1:0] A_WHI  = 3'd4;
  localparam logic [AW-1:0] A_RLO  = 3'd5;
  localparam logic [AW-1:0] A_RHI  = 3'd6;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic last_o
);
  localparam int unsigned PW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (!run_i || last_o) ph_q <= '0;
    else                       ph_q <= ph_q + PW'(1);
  end

  assign mdc_o  = run_i && (ph_q >= PW'(HALF));
  assign rise_o = run_i && (ph_q == PW'(HALF));
  assign last_o = run_i && (ph_q == PW'(DIV - 1));
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng import mgmt_pkg::*; #(
  parameter int unsigned     CLK_DIV  = 4,
  parameter logic [RA_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_rd_i,
  input  logic [RA_W-1:0]   reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned CW = $clog2(TOT_BITS);

  logic              active_q, is_rd_q;
  logic [CW-1:0]     bit_q;
  logic [FRM_LEN-1:0] sr_q;
  logic [DATA_W-1:0] rx_q;
  logic              rise, last, last_bit, in_pre;

  mgmt_mdc_gen #(.DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .last_o (last)
  );

  assign last_bit = (bit_q == CW'(TOT_BITS - 1));
  assign in_pre   = (bit_q < CW'(PRE_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      is_rd_q  <= op_rd_i;
      bit_q    <= '0;
      sr_q     <= {SOF, op_rd_i ? OP_RD : OP_WR, PHY_ADDR, reg_i,
                   op_rd_i ? 2'b00 : TA_WR,
                   op_rd_i ? {DATA_W{1'b0}} : wdata_i};
    end else if (last) begin
      if (last_bit) active_q <= 1'b0;
      else          bit_q    <= bit_q + CW'(1);
      if (!in_pre)  sr_q     <= {sr_q[FRM_LEN-2:0], 1'b0};
    end
  end

  // reply bits shift in on MDC rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= '0;
    else if (rise && is_rd_q && (bit_q >= CW'(DAT_BIT))) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
  end

  assign busy_o    = active_q;
  assign rd_done_o = last && last_bit && is_rd_q;
  assign rx_o      = rx_q;
  assign mdio_o    = active_q && (in_pre || sr_q[FRM_LEN-1]);
  assign mdio_oe_o = active_q && !(is_rd_q && (bit_q >= CW'(TA_BIT)));
endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs import mgmt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              start_o,
  output logic              op_rd_o,
  output logic [DATA_W-1:0] wword_o,
  output logic [RA_W-1:0]   sel_o,
  output logic              rd_bit_o,
  output logic              scan_bit_o,
  output logic [7:0]        wlo_o,
  output logic [7:0]        whi_o,
  output logic [DATA_W-1:0] rword_o
);
  logic [RA_W-1:0]   sel_q;
  logic              rd_q, scan_q, rd_nxt, scan_nxt;
  logic [7:0]        wlo_q, whi_q;
  logic [DATA_W-1:0] rword_q;
  logic              cmd_we, whi_hit, rd_set;

  assign cmd_we  = we_i && (addr_i == A_CMD);
  assign whi_hit = we_i && (addr_i == A_WHI) && !busy_i;
  assign rd_set  = cmd_we && !busy_i && wdata_i[0] && !rd_q;

  // while busy only clearing is accepted
  always_comb begin
    rd_nxt   = rd_q;
    scan_nxt = scan_q;
    if (cmd_we) begin
      if (busy_i) begin
        rd_nxt   = rd_q & wdata_i[0];
        scan_nxt = scan_q & wdata_i[1];
      end else begin
        rd_nxt   = wdata_i[0];
        scan_nxt = wdata_i[1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      rd_q    <= 1'b0;
      scan_q  <= 1'b0;
      wlo_q   <= '0;
      whi_q   <= '0;
      rword_q <= '0;
    end else begin
      rd_q   <= rd_nxt;
      scan_q <= scan_nxt;
      if (we_i && (addr_i == A_SEL)) sel_q <= wdata_i[RA_W-1:0];
      if (we_i && (addr_i == A_WLO)) wlo_q <= wdata_i;
      if (whi_hit)                   whi_q <= wdata_i;
      if (rd_done_i)                 rword_q <= rx_i;
    end
  end

  assign start_o    = !busy_i && (whi_hit || rd_set || scan_nxt);
  assign op_rd_o    = !whi_hit;
  assign wword_o    = {wdata_i, wlo_q};
  assign sel_o      = sel_q;
  assign rd_bit_o   = rd_q;
  assign scan_bit_o = scan_q;
  assign wlo_o      = wlo_q;
  assign whi_o      = whi_q;
  assign rword_o    = rword_q;
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge import mgmt_pkg::*; #(
  parameter int unsigned     CLK_DIV  = 4,
  parameter logic [RA_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy, start, op_rd, rd_done, rd_bit, scan_bit;
  logic [DATA_W-1:0] rx_word, wword, rword;
  logic [RA_W-1:0]   sel;
  logic [7:0]        wlo, whi;

  mgmt_host_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .rd_done_i  (rd_done),
    .rx_i       (rx_word),
    .start_o    (start),
    .op_rd_o    (op_rd),
    .wword_o    (wword),
    .sel_o      (sel),
    .rd_bit_o   (rd_bit),
    .scan_bit_o (scan_bit),
    .wlo_o      (wlo),
    .whi_o      (whi),
    .rword_o    (rword)
  );

  mgmt_frame_eng #(.CLK_DIV(CLK_DIV), .PHY_ADDR(PHY_ADDR)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_rd_i   (op_rd),
    .reg_i     (sel),
    .wdata_i   (wword),
    .busy_o    (busy),
    .rd_done_o (rd_done),
    .rx_o      (rx_word),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .mdio_i    (mdio_i)
  );

  always_comb begin
    case (reg_addr_i)
      A_SEL:   reg_rdata_o = {{(8-RA_W){1'b0}}, sel};
      A_CMD:   reg_rdata_o = {6'b0, scan_bit, rd_bit};
      A_STAT:  reg_rdata_o = {7'b0, busy};
      A_WLO:   reg_rdata_o = wlo;
      A_WHI:   reg_rdata_o = whi;
      A_RLO:   reg_rdata_o = rword[7:0];
      A_RHI:   reg_rdata_o = rword[15:8];
      default: reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk #(
  parameter int unsigned CLK_DIV = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       start_i,
  input logic       mdc_i,
  input logic       mdio_i,
  input logic       mdio_oe_i,
  input logic [7:0] whi_i
);
  localparam int unsigned FRAME_CYC = 64 * CLK_DIV;
  localparam int unsigned CW        = $clog2(FRAME_CYC + 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_i) busy_cnt <= busy_cnt + CW'(1);
    else             busy_cnt <= '0;
  end

  AST_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i)); // R1

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i); // R2

  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (busy_cnt == CW'(FRAME_CYC))); // R3

  AST_EDGE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_i) |-> ($stable(mdio_i) && $stable(mdio_oe_i))); // R6

  AST_WHI_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(whi_i)); // R9
endmodule

bind mgmt_bridge mgmt_bridge_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .start_i   (start),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .mdio_oe_i (mdio_oe_o),
  .whi_i     (whi)
);

// File: tb/mgmt_bridge_test.sv
module mgmt_bridge_test;
  localparam int DIV   = 4;
  localparam int FRAME = 64 * DIV;
  localparam logic [4:0] PHY = 5'd1;

  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0, mdio_in;
  logic [2:0] addr = 3'd0;
  logic [7:0] wd = 8'h00, rdata;
  logic       mdc, mdio, oe;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  mgmt_bridge #(.CLK_DIV(DIV), .PHY_ADDR(PHY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio),
    .mdio_oe_o(oe), .mdio_i(mdio_in));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic        m_busy, m_op_rd, m_rd, m_scan;
  int          m_k;
  logic [63:0] m_frame;
  logic [4:0]  m_sel;
  logic [7:0]  m_wlo, m_whi;
  logic [15:0] m_rdat, phy_val = 16'h0000;

  always @(posedge clk or negedge rst_n) begin
    logic go, go_rd, nrd, nscan;
    logic [15:0] wdat;
    if (!rst_n) begin
      m_busy <= 0; m_op_rd <= 0; m_rd <= 0; m_scan <= 0; m_k <= 0;
      m_frame <= '0; m_sel <= '0; m_wlo <= '0; m_whi <= '0; m_rdat <= '0;
    end else begin
      go = 0; go_rd = 1; nrd = m_rd; nscan = m_scan; wdat = '0;
      if (we) begin
        case (addr)
          3'd0: m_sel <= wd[4:0];
          3'd1: begin
            if (m_busy) begin nrd = m_rd & wd[0]; nscan = m_scan & wd[1]; end
            else begin
              nrd = wd[0]; nscan = wd[1];
              if (wd[0] && !m_rd) go = 1;
            end
          end
          3'd3: m_wlo <= wd;
          3'd4: if (!m_busy) begin m_whi <= wd; go = 1; go_rd = 0; wdat = {wd, m_wlo}; end
          default: ;
        endcase
      end
      if (!m_busy && nscan) go = 1;
      m_rd <= nrd; m_scan <= nscan;
      if (m_busy) begin
        if (m_k == FRAME - 1) begin
          m_busy <= 0;
          if (m_op_rd) m_rdat <= phy_val;
        end else m_k <= m_k + 1;
      end else if (go) begin
        m_busy <= 1; m_k <= 0; m_op_rd <= go_rd;
        m_frame <= {32'hFFFF_FFFF, 2'b01, go_rd ? 2'b10 : 2'b01, PHY, m_sel,
                    go_rd ? 2'b00 : 2'b10, go_rd ? 16'h0000 : wdat};
      end
    end
  end

  // PHY reply during the data bits of a read
  always_comb begin
    mdio_in = 1'b1;
    if (m_busy && m_op_rd && (m_k / DIV) >= 48) mdio_in = phy_val[15 - (m_k / DIV - 48)];
  end

  // every-cycle comparison
  always @(negedge clk) begin
    logic [7:0] er;
    string t;
    if (rst_n) begin
      chk("R6 mdc", mdc, m_busy && (m_k % DIV) >= DIV / 2);
      chk("R5 mdio_oe", oe, m_busy && !(m_op_rd && (m_k / DIV) >= 46));
      if (m_busy && !(m_op_rd && (m_k / DIV) >= 46)) chk("R4 mdio bit", mdio, m_frame[63 - m_k / DIV]);
      case (addr)
        3'd0: begin er = {3'b0, m_sel}; t = "R1 select"; end
        3'd1: begin er = {6'b0, m_scan, m_rd}; t = "R8 command"; end
        3'd2: begin er = {7'b0, m_busy}; t = "R3 busy"; end
        3'd3: begin er = m_wlo; t = "R4 wlo"; end
        3'd4: begin er = m_whi; t = "R9 whi"; end
        3'd5: begin er = m_rdat[7:0]; t = "R7 rlo"; end
        3'd6: begin er = m_rdat[15:8]; t = "R7 rhi"; end
        default: begin er = 8'h00; t = "R1 unused"; end
      endcase
      chk(t, rdata, er);
    end
  end

  // independent capture of driven bits at MDC rise
  logic [63:0] cap = '0;
  always @(posedge mdc) if (oe) cap = {cap[62:0], mdio};

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2; we = 1; addr = a; wd = d;
    @(posedge clk); #2; we = 0; addr = 3'd2;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2; addr = a;
    @(negedge clk); chk(tag, rdata, e);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_busy && n < 2000) begin @(posedge clk); n++; end
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    for (int a = 0; a < 8; a++) rchk(3'(a), 8'h00, "R1 reset value");
    chk("R1 reset mdc/oe", {mdc, oe}, 2'b00);

    // write frame
    wr(3'd0, 8'h1A); wr(3'd3, 8'h34);
    cap = '0;
    wr(3'd4, 8'h12);
    rchk(3'd2, 8'h01, "R2 busy after high byte");
    repeat (100) @(posedge clk);
    wr(3'd4, 8'h99);
    wr(3'd1, 8'h01);
    rchk(3'd1, 8'h00, "R9 read set ignored");
    wait_idle();
    chk("R4 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, 5'h1A, 2'b10, 16'h1234});
    rchk(3'd4, 8'h12, "R9 high byte kept");
    rchk(3'd2, 8'h00, "R3 busy cleared");

    // read frame
    phy_val = 16'hA5C3;
    wr(3'd0, 8'h03); wr(3'd1, 8'h01);
    wait_idle();
    rchk(3'd6, 8'hA5, "R7 high first");
    rchk(3'd5, 8'hC3, "R7 low second");
    rchk(3'd6, 8'hA5, "R7 high again");
    rchk(3'd1, 8'h01, "R8 sticky");
    wr(3'd1, 8'h01);
    repeat (3) @(posedge clk);
    rchk(3'd2, 8'h00, "R8 no relaunch");
    wr(3'd1, 8'h00);
    phy_val = 16'h5A0F;
    wr(3'd1, 8'h01);
    rchk(3'd2, 8'h01, "R5 read started");
    wait_idle();
    rchk(3'd5, 8'h0F, "R7 second read low");
    rchk(3'd6, 8'h5A, "R7 second read high");

    // back-to-back writes
    wr(3'd3, 8'h00); wr(3'd4, 8'h80);
    wait_idle();
    wr(3'd4, 8'h7F);
    rchk(3'd2, 8'h01, "R2 write right after busy");
    wait_idle();
    rchk(3'd4, 8'h7F, "R2 high byte stored");

    // scan
    wr(3'd1, 8'h00);
    phy_val = 16'h1234;
    wr(3'd1, 8'h02);
    repeat (300) @(posedge clk);
    rchk(3'd5, 8'h34, "R10 scan updates data");
    wr(3'd1, 8'h03);
    rchk(3'd1, 8'h02, "R9 read set ignored in scan");
    wr(3'd1, 8'h00);
    rchk(3'd2, 8'h01, "R10 frame continues");
    wait_idle();
    repeat (5) @(posedge clk);
    rchk(3'd2, 8'h00, "R10 scan stopped");
    rchk(3'd6, 8'h12, "R10 last data");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule